// File: doc/BRIEF.md
# Procedure Frame Sequencer

This unit builds and tears down procedure stack frames over several clock cycles. An enter command takes the current stack and frame pointers, a 16-bit local-space size and an 8-bit nesting depth. The unit pushes the old frame pointer. For a nested call it copies the enclosing frame pointers, reading them downward from the old frame. It then pushes the new frame value, lowers the stack pointer by the local size and ends with a probe of the final stack address. A leave command reloads the frame pointer from the word it points to and sets the stack pointer just above that word.

All stack traffic goes through a single word-wide memory port with read, write and probe operations, and every access waits for a ready handshake. A width bit selects full-width pointer arithmetic, or 16-bit arithmetic that wraps within the low half. The committed pointer outputs change only when a whole command completes. An error reported by the memory port cancels the command and leaves the committed pointers as they were.

Top module: `frame_seq`

## Requirements
- R1: Only the low 5 bits of the nesting depth are used, so depth 33 acts as depth 1 and depth 32 acts as depth 0.
- R2: Enter first writes fpIn at stack address spIn-4. That decremented stack value becomes the committed frame pointer.
- R3: For a masked depth L>0, enter makes L-1 read/write pairs. Pair k reads at fpIn-4k and writes the word read at the next lower stack slot. A write of the new frame value at the next lower slot follows.
- R4: After the pushes, the stack pointer is lowered by the local size. The last access of an enter is a probe (memOp=2) at that final stack address, and the final address is committed as spOut.
- R5: spOut and fpOut change only at the clock edge that raises done. done is a one-cycle pulse.
- R6: Leave reads at address fpIn (memOp=0). It then commits spOut = fpIn+4 and fpOut = the word read.
- R7: With wideMode=0, every pointer step changes only bits 15:0 and wraps within them. Bits 31:16 of the stack pointer are kept, and memAddr carries zeros in bits 31:16.
- R8: A memErr seen with memReady ends the command at once: abort pulses for one cycle, done stays low, and spOut and fpOut hold.
- R9: busy is high from the cycle after a command is accepted until the cycle done or abort pulses. cmdValid while busy is ignored.
- R10: memReq is high in every busy cycle. memOp (0 read, 1 write, 2 probe), memAddr and memWdata hold steady until memReady.
- R11: After reset busy, done, abort and memReq are 0, and spOut and fpOut are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Start a command when idle |
| cmdLeave | input | 1 | 1 = leave, 0 = enter |
| wideMode | input | 1 | 1 = 32-bit pointer arithmetic, 0 = 16-bit |
| allocSize | input | 16 | Local space in bytes for enter |
| nestLevel | input | 8 | Nesting depth for enter (low 5 bits used) |
| spIn | input | 32 | Stack pointer at command start |
| fpIn | input | 32 | Frame pointer at command start |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| abort | output | 1 | One-cycle pulse on memory error |
| spOut | output | 32 | Committed stack pointer |
| fpOut | output | 32 | Committed frame pointer |
| memReq | output | 1 | Memory access request |
| memOp | output | 2 | 0 read, 1 write, 2 probe |
| memAddr | output | 32 | Access address |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid with memReady |
| memReady | input | 1 | Access completes this cycle |
| memErr | input | 1 | Access failed (sampled with memReady) |

## Verification
On every cycle the assertions check that a pending request holds steady, that the pointers move only with done and never with abort, and that busy falls only with a done or abort pulse. They also check that a completed probe always leads to done and that only legal operation codes appear. The exact access order, the addresses of the frame walk, the 16-bit wrap, the depth masking and the final pointer values can only be shown by the bench. Its reference model predicts each access and each output cycle for the chosen depths, sizes, latencies and error points.

// File: rtl/frame_pkg.sv
package frame_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_PROBE = 2'd2
  } memOp_e;

  typedef enum logic [1:0] {
    ADR_PUSH,
    ADR_WALK,
    ADR_ALLOC,
    ADR_FRAME
  } adrSel_e;

  typedef enum logic [1:0] {
    WD_OLDFP,
    WD_COPY,
    WD_NEWFP
  } wdSel_e;

  typedef struct packed {
    logic    loadCmd;
    logic    stepPush;
    logic    setFrame;
    logic    stepWalk;
    logic    latchRd;
    logic    decCnt;
    logic    commitEnter;
    logic    commitLeave;
    adrSel_e adrSel;
    wdSel_e  wdSel;
  } ctrlStrb_t;
endpackage

// File: rtl/frame_datapath.sv
module frame_datapath
  import frame_pkg::*;
#(
  parameter int PTR_W    = 32,
  parameter int SIZE_W   = 16,
  parameter int LVL_W    = 8,
  parameter int LVL_BITS = 5,
  parameter int STEP     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic              wideMode,
  input  logic [SIZE_W-1:0] allocSize,
  input  logic [LVL_W-1:0]  nestLevel,
  input  logic [PTR_W-1:0]  spIn,
  input  logic [PTR_W-1:0]  fpIn,
  input  logic [PTR_W-1:0]  memRdata,
  output logic [PTR_W-1:0]  memAddr,
  output logic [PTR_W-1:0]  memWdata,
  output logic [PTR_W-1:0]  spOut,
  output logic [PTR_W-1:0]  fpOut,
  output logic              cntZero,
  output logic              cntOne,
  output logic              cntTwo
);
  localparam int HALF_W = PTR_W / 2;
  localparam logic [PTR_W-1:0] STEP_UP   = PTR_W'(STEP);
  localparam logic [PTR_W-1:0] STEP_DOWN = '0 - STEP_UP;
  localparam logic [LVL_W-1:0] LVL_MASK  = LVL_W'((1 << LVL_BITS) - 1);

  logic [PTR_W-1:0]  spW, workW, frameW, rdW;
  logic [SIZE_W-1:0] allocW;
  logic              wideW;
  logic [LVL_W-1:0]  cnt;

  function automatic logic [PTR_W-1:0] stepPtr(
    input logic [PTR_W-1:0] base,
    input logic [PTR_W-1:0] delta,
    input logic             full
  );
    logic [HALF_W-1:0] lo;
    lo = base[HALF_W-1:0] + delta[HALF_W-1:0];
    return full ? base + delta : {base[PTR_W-1:HALF_W], lo};
  endfunction

  function automatic logic [PTR_W-1:0] toAddr(input logic [PTR_W-1:0] v, input logic full);
    return full ? v : {{(PTR_W-HALF_W){1'b0}}, v[HALF_W-1:0]};
  endfunction

  logic [PTR_W-1:0] pushNext, walkNext, allocNext, leaveSp;
  always_comb begin
    pushNext  = stepPtr(spW, STEP_DOWN, wideW);
    walkNext  = stepPtr(workW, STEP_DOWN, wideW);
    allocNext = stepPtr(spW, '0 - PTR_W'(allocW), wideW);
    leaveSp   = wideW ? workW + STEP_UP
                      : {spW[PTR_W-1:HALF_W], workW[HALF_W-1:0] + STEP_UP[HALF_W-1:0]};
  end

  always_comb begin
    unique case (strb.adrSel)
      ADR_PUSH:  memAddr = toAddr(pushNext, wideW);
      ADR_WALK:  memAddr = toAddr(walkNext, wideW);
      ADR_ALLOC: memAddr = toAddr(allocNext, wideW);
      default:   memAddr = toAddr(workW, wideW);
    endcase
    unique case (strb.wdSel)
      WD_COPY:  memWdata = rdW;
      WD_NEWFP: memWdata = frameW;
      default:  memWdata = workW;
    endcase
  end

  assign cntZero = (cnt == '0);
  assign cntOne  = (cnt == LVL_W'(1));
  assign cntTwo  = (cnt == LVL_W'(2));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      spW <= '0; workW <= '0; frameW <= '0; rdW <= '0;
      allocW <= '0; wideW <= 1'b1; cnt <= '0;
      spOut <= '0; fpOut <= '0;
    end else begin
      if (strb.loadCmd) begin
        spW    <= spIn;
        workW  <= fpIn;
        allocW <= allocSize;
        wideW  <= wideMode;
        cnt    <= nestLevel & LVL_MASK;
      end
      if (strb.stepPush) spW    <= pushNext;
      if (strb.setFrame) frameW <= pushNext;
      if (strb.stepWalk) workW  <= walkNext;
      if (strb.latchRd)  rdW    <= memRdata;
      if (strb.decCnt)   cnt    <= cnt - LVL_W'(1);
      if (strb.commitEnter) begin
        spOut <= allocNext;
        fpOut <= frameW;
      end
      if (strb.commitLeave) begin
        spOut <= leaveSp;
        fpOut <= memRdata;
      end
    end
  end

  // R7: in narrow mode the upper half of the working stack pointer never moves
  a_r7_upper_half_kept: assert property (@(posedge clk) disable iff (!rstN)
    (!wideW && !strb.loadCmd) |=> spW[PTR_W-1:HALF_W] == $past(spW[PTR_W-1:HALF_W]));
endmodule

// File: rtl/frame_ctrl.sv
module frame_ctrl
  import frame_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdValid,
  input  logic      cmdLeave,
  input  logic      memReady,
  input  logic      memErr,
  input  logic      cntZero,
  input  logic      cntOne,
  input  logic      cntTwo,
  output ctrlStrb_t strb,
  output logic      memReq,
  output logic [1:0] memOp,
  output logic      busy,
  output logic      done,
  output logic      abort
);
  typedef enum logic [2:0] {
    S_IDLE, S_PUSH_OLD, S_COPY_RD, S_COPY_WR, S_PUSH_NEW, S_PROBE, S_LEAVE_RD
  } state_e;

  state_e state, stateNxt;
  logic   accOk, accBad;
  memOp_e opNow;

  assign accOk  = memReady && !memErr;
  assign accBad = memReady && memErr;
  assign busy   = (state != S_IDLE);
  assign memReq = busy;
  assign memOp  = opNow;

  always_comb begin
    strb     = '0;
    strb.adrSel = ADR_PUSH;
    strb.wdSel  = WD_OLDFP;
    opNow    = OP_READ;
    stateNxt = state;
    unique case (state)
      S_IDLE: if (cmdValid) begin
        strb.loadCmd = 1'b1;
        stateNxt = cmdLeave ? S_LEAVE_RD : S_PUSH_OLD;
      end
      S_PUSH_OLD: begin
        opNow = OP_WRITE;
        if (accOk) begin
          strb.stepPush = 1'b1;
          strb.setFrame = 1'b1;
          stateNxt = cntZero ? S_PROBE : (cntOne ? S_PUSH_NEW : S_COPY_RD);
        end
      end
      S_COPY_RD: begin
        strb.adrSel = ADR_WALK;
        if (accOk) begin
          strb.stepWalk = 1'b1;
          strb.latchRd  = 1'b1;
          stateNxt = S_COPY_WR;
        end
      end
      S_COPY_WR: begin
        opNow = OP_WRITE;
        strb.wdSel = WD_COPY;
        if (accOk) begin
          strb.stepPush = 1'b1;
          strb.decCnt   = 1'b1;
          stateNxt = cntTwo ? S_PUSH_NEW : S_COPY_RD;
        end
      end
      S_PUSH_NEW: begin
        opNow = OP_WRITE;
        strb.wdSel = WD_NEWFP;
        if (accOk) begin
          strb.stepPush = 1'b1;
          stateNxt = S_PROBE;
        end
      end
      S_PROBE: begin
        opNow = OP_PROBE;
        strb.adrSel = ADR_ALLOC;
        if (accOk) begin
          strb.commitEnter = 1'b1;
          stateNxt = S_IDLE;
        end
      end
      default: begin
        strb.adrSel = ADR_FRAME;
        if (accOk) begin
          strb.commitLeave = 1'b1;
          stateNxt = S_IDLE;
        end
      end
    endcase
    if (busy && accBad) begin
      strb.stepPush = 1'b0; strb.setFrame = 1'b0; strb.stepWalk = 1'b0;
      strb.latchRd = 1'b0; strb.decCnt = 1'b0;
      strb.commitEnter = 1'b0; strb.commitLeave = 1'b0;
      stateNxt = S_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      done  <= 1'b0;
      abort <= 1'b0;
    end else begin
      state <= stateNxt;
      done  <= busy && accOk && (state == S_PROBE || state == S_LEAVE_RD);
      abort <= busy && accBad;
    end
  end

  // R4: a completed probe always finishes the enter
  a_r4_probe_then_done: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_PROBE && accOk) |=> done);
  // R3: the copy loop is entered only while copies remain
  a_r3_copy_needs_depth: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_COPY_RD) |-> !cntZero && !cntOne);
  // R10: only the three defined operation codes appear
  a_r10_op_legal: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memOp != 2'd3));
endmodule

// File: rtl/frame_seq.sv
module frame_seq
  import frame_pkg::*;
#(
  parameter int PTR_W    = 32,
  parameter int SIZE_W   = 16,
  parameter int LVL_W    = 8,
  parameter int LVL_BITS = 5,
  parameter int STEP     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic              cmdLeave,
  input  logic              wideMode,
  input  logic [SIZE_W-1:0] allocSize,
  input  logic [LVL_W-1:0]  nestLevel,
  input  logic [PTR_W-1:0]  spIn,
  input  logic [PTR_W-1:0]  fpIn,
  output logic              busy,
  output logic              done,
  output logic              abort,
  output logic [PTR_W-1:0]  spOut,
  output logic [PTR_W-1:0]  fpOut,
  output logic              memReq,
  output logic [1:0]        memOp,
  output logic [PTR_W-1:0]  memAddr,
  output logic [PTR_W-1:0]  memWdata,
  input  logic [PTR_W-1:0]  memRdata,
  input  logic              memReady,
  input  logic              memErr
);
  ctrlStrb_t strb;
  logic cntZero, cntOne, cntTwo;

  frame_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdLeave(cmdLeave),
    .memReady(memReady), .memErr(memErr),
    .cntZero(cntZero), .cntOne(cntOne), .cntTwo(cntTwo),
    .strb(strb), .memReq(memReq), .memOp(memOp),
    .busy(busy), .done(done), .abort(abort)
  );

  frame_datapath #(
    .PTR_W(PTR_W), .SIZE_W(SIZE_W), .LVL_W(LVL_W), .LVL_BITS(LVL_BITS), .STEP(STEP)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wideMode(wideMode),
    .allocSize(allocSize), .nestLevel(nestLevel), .spIn(spIn), .fpIn(fpIn),
    .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .spOut(spOut), .fpOut(fpOut),
    .cntZero(cntZero), .cntOne(cntOne), .cntTwo(cntTwo)
  );

  // R10: a waiting request keeps its operation, address and data
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> memReq && $stable(memOp) && $stable(memAddr) && $stable(memWdata));
  // R5: committed pointers move only together with done
  a_r5_commit_with_done: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(spOut) && $stable(fpOut));
  // R8: an aborted command never raises done
  a_r8_abort_not_done: assert property (@(posedge clk) disable iff (!rstN)
    !(abort && done));
  // R9: busy ends only with a completion or an abort pulse
  a_r9_busy_end: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (done || abort));
endmodule

// File: tb/test_frame_seq.sv
`timescale 1ns/1ps
module test_frame_seq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0, cmdLeave = 1'b0, wideMode = 1'b1;
  logic [15:0] allocSize = '0;
  logic [7:0]  nestLevel = '0;
  logic [31:0] spIn = '0, fpIn = '0;
  logic        busy, done, abort, memReq;
  logic [31:0] spOut, fpOut, memAddr, memWdata;
  logic [1:0]  memOp;
  logic [31:0] memRdata = '0;
  logic        memReady = 1'b0, memErr = 1'b0;

  always #4 clk = ~clk;

  frame_seq i_frame_seq (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdLeave(cmdLeave),
    .wideMode(wideMode), .allocSize(allocSize), .nestLevel(nestLevel),
    .spIn(spIn), .fpIn(fpIn), .busy(busy), .done(done), .abort(abort),
    .spOut(spOut), .fpOut(fpOut), .memReq(memReq), .memOp(memOp),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .memReady(memReady), .memErr(memErr)
  );

  typedef struct {
    logic [1:0]  op;
    logic [31:0] addr;
    logic [31:0] data;
  } acc_t;

  acc_t        expQ[$];
  logic [31:0] mem[logic [31:0]];
  int          checks = 0, errors = 0, cycles = 0;
  string       curReq = "R11";
  logic        expBusy = 0, expDone = 0, expAbort = 0;
  logic [31:0] expSp = '0, expFp = '0, finSp = '0, finFp = '0;
  int          lat = 0, errIdx = -1, waitCnt = 0, accIdx = 0;

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", curReq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] peek(logic [31:0] a);
    return mem.exists(a) ? mem[a] : (a ^ 32'hC0DE_0000);
  endfunction

  function automatic logic [31:0] mStep(logic [31:0] v, logic [31:0] d, logic w);
    logic [15:0] lo;
    lo = v[15:0] + d[15:0];
    return w ? v + d : {v[31:16], lo};
  endfunction

  function automatic logic [31:0] mAddr(logic [31:0] v, logic w);
    return w ? v : {16'h0, v[15:0]};
  endfunction

  function automatic void addAcc(logic [1:0] op, logic [31:0] a, logic [31:0] d);
    acc_t e;
    e.op = op; e.addr = a; e.data = d;
    expQ.push_back(e);
  endfunction

  // Reference model: build the expected access list and final pointers
  function automatic void buildCmd();
    logic w = wideMode;
    logic [31:0] sp = spIn, work = fpIn, frame, v;
    int depth = int'(nestLevel) % 32;
    expQ.delete();
    if (cmdLeave) begin
      addAcc(2'd0, mAddr(fpIn, w), 32'h0);
      finSp = w ? fpIn + 32'd4 : {spIn[31:16], fpIn[15:0] + 16'd4};
      finFp = peek(mAddr(fpIn, w));
    end else begin
      sp = mStep(sp, -32'd4, w);
      addAcc(2'd1, mAddr(sp, w), fpIn);
      frame = sp;
      if (depth > 0) begin
        for (int k = 1; k < depth; k++) begin
          work = mStep(work, -32'd4, w);
          addAcc(2'd0, mAddr(work, w), 32'h0);
          v = peek(mAddr(work, w));
          sp = mStep(sp, -32'd4, w);
          addAcc(2'd1, mAddr(sp, w), v);
        end
        sp = mStep(sp, -32'd4, w);
        addAcc(2'd1, mAddr(sp, w), frame);
      end
      sp = mStep(sp, 32'd0 - {16'h0, allocSize}, w);
      addAcc(2'd2, mAddr(sp, w), 32'h0);
      finSp = sp;
      finFp = frame;
    end
  endfunction

  // Cycle-by-cycle comparison and memory responder
  always @(negedge clk) begin
    if (rstN) begin
      cycles++;
      chk("busy", {31'h0, busy}, {31'h0, expBusy});
      chk("done", {31'h0, done}, {31'h0, expDone});
      chk("abort", {31'h0, abort}, {31'h0, expAbort});
      chk("memReq", {31'h0, memReq}, {31'h0, expBusy});
      chk("spOut", spOut, expSp);
      chk("fpOut", fpOut, expFp);
      expDone = 0; expAbort = 0;
      memReady = 0; memErr = 0;
      if (cmdValid && !expBusy) begin
        buildCmd();
        expBusy = 1; waitCnt = 0; accIdx = 0;
      end else if (expBusy && memReq) begin
        if (waitCnt >= lat && expQ.size() > 0) begin
          acc_t e;
          e = expQ.pop_front();
          chk("memOp", {30'h0, memOp}, {30'h0, e.op});
          chk("memAddr", memAddr, e.addr);
          if (e.op == 2'd1) chk("memWdata", memWdata, e.data);
          memReady = 1;
          memRdata = peek(memAddr);
          waitCnt = 0;
          if (accIdx == errIdx) begin
            memErr = 1;
            expQ.delete();
            expAbort = 1; expBusy = 0;
          end else begin
            if (memOp == 2'd1) mem[memAddr] = memWdata;
            if (expQ.size() == 0) begin
              expDone = 1; expBusy = 0;
              expSp = finSp; expFp = finFp;
            end
          end
          accIdx++;
        end else begin
          waitCnt++;
        end
      end
      if (cycles > 50000) begin
        errors++;
        $display("FAIL watchdog: got %0d cycles expected completion", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  task automatic runCmd(string tag, logic leave, logic w, logic [15:0] alloc,
                        logic [7:0] lvl, logic [31:0] sp, logic [31:0] fp,
                        int latency, int failAt, logic intrude);
    @(posedge clk); #1;
    curReq = tag; lat = latency; errIdx = failAt;
    cmdLeave = leave; wideMode = w; allocSize = alloc; nestLevel = lvl;
    spIn = sp; fpIn = fp; cmdValid = 1;
    @(posedge clk); #1;
    cmdValid = 0;
    if (intrude) begin
      // R9: a second command during busy must be ignored
      @(posedge clk); #1;
      cmdValid = 1; cmdLeave = 1; spIn = 32'hDEAD_0000; fpIn = 32'hBEEF_0000;
      @(posedge clk); #1;
      cmdValid = 0;
    end
    while (expBusy) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk); #1;
    curReq = "R11";
    chk("reset busy", {31'h0, busy}, 32'h0);
    chk("reset memReq", {31'h0, memReq}, 32'h0);
    chk("reset spOut", spOut, 32'h0);
    chk("reset fpOut", fpOut, 32'h0);
    runCmd("R2 R4 R5", 0, 1, 16'h0010, 8'd0,  32'h0000_1800, 32'h0000_2000, 0, -1, 0);
    runCmd("R3 R10",   0, 1, 16'h0020, 8'd3,  32'h0000_1800, 32'h0000_2000, 2, -1, 0);
    runCmd("R1 depth33", 0, 1, 16'h0008, 8'd33, 32'h0000_1800, 32'h0000_2000, 1, -1, 0);
    runCmd("R1 depth32", 0, 1, 16'h0004, 8'd32, 32'h0000_1700, 32'h0000_2100, 0, -1, 0);
    runCmd("R6",       1, 1, 16'h0000, 8'd0,  32'h0000_1000, 32'h0000_2000, 1, -1, 0);
    runCmd("R7 enter", 0, 0, 16'h0010, 8'd2,  32'hABCD_0002, 32'h1234_0010, 1, -1, 0);
    runCmd("R7 leave", 1, 0, 16'h0000, 8'd0,  32'h7777_0100, 32'h5555_FFFE, 0, -1, 0);
    runCmd("R8 enter", 0, 1, 16'h0040, 8'd3,  32'h0000_3800, 32'h0000_4000, 1, 3, 0);
    runCmd("R8 leave", 1, 1, 16'h0000, 8'd0,  32'h0000_1000, 32'h0000_5000, 2, 0, 0);
    runCmd("R9",       0, 1, 16'h0100, 8'd4,  32'h0000_6800, 32'h0000_7000, 2, -1, 1);
    runCmd("R4 wide wrap", 0, 1, 16'hFFFF, 8'd1, 32'h0000_0010, 32'h0000_0100, 0, -1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule